// File: doc/BRIEF.md
# Block Transfer Bank-Select Sequencer

This block walks a decoded load-multiple or store-multiple instruction through its register list, one register per clock. For each listed register it emits the register index, a bank select, a word address and a write strobe. The bank select chooses between the current mode's bank and the user bank. The write strobe is asserted for stores, which read the register file and write memory. The register file, the memory bus and any wait states belong to the surrounding core. The sequencer only supplies the order and the addressing.

The S flag gives the instruction a second meaning. On a privileged load whose list contains the program counter (register 15), the S flag requests a saved-to-current status copy. This copy is pulsed in the same cycle as the register 15 transfer. In every other privileged case, the S flag redirects all transfers to the user bank. That redirection forbids base writeback. After a user-bank load, banked registers must not be read in the next cycle, so a one-cycle hazard is raised. Illegal combinations are flagged, but the transfer still runs.

An instruction is accepted only while the block is idle. A done pulse closes every instruction, and any base writeback value is presented together with that pulse.

Top module: `bts_seq`

## Requirements
- R1: A privileged load with S set and register 15 in the list pulses `psr_restore` in exactly the cycle where `xfer_idx` is 15, with `xfer_user_bank` low on every transfer of that instruction.
- R2: A privileged store with S set and register 15 in the list issues every transfer, including index 15, with `xfer_user_bank` high and `xfer_write` high, and no `psr_restore`.
- R3: With S set in a privileged mode and register 15 absent, both loads and stores issue every transfer with `xfer_user_bank` high.
- R4: When S and writeback are both set, `illegal` pulses in the cycle after acceptance and `wb_valid` stays low at done. Without S, a requested writeback shows `wb_valid` high with `wb_value` at done.
- R5: In user mode (`cur_mode` = 0), a set S flag pulses `illegal` and is otherwise ignored: current bank, no status copy, no hazard.
- R6: `hazard` is high for exactly the done cycle of a user-bank load with a non-empty list, and low otherwise.
- R7: `amode` encodings are 0 increment-after, 1 increment-before, 2 decrement-after and 3 decrement-before. For n registers, the first address and the writeback value are, respectively:
  - increment-after: base and base+4n
  - increment-before: base+4 and base+4n
  - decrement-after: base-4n+4 and base-4n
  - decrement-before: base-4n and base-4n
- R8: Transfers appear in ascending register index order, the lowest index at the lowest address, each address 4 above the previous.
- R9: An empty list produces no transfers and no status copy, and pulses `done` in the second cycle after acceptance. Writeback, if allowed, equals the base.
- R10: `done` pulses in the cycle after the last transfer. `start` is ignored while `busy` is high.
- R11: After reset, every output is low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction valid, taken only when idle |
| is_load | input | 1 | 1 = load-multiple, 0 = store-multiple |
| s_flag | input | 1 | S flag of the instruction |
| wb_flag | input | 1 | Base writeback requested |
| amode | input | 2 | Addressing mode (R7 encoding) |
| base | input | 32 | Base register value |
| reg_list | input | 16 | Register list, bit i selects register i |
| cur_mode | input | 3 | Current processor mode, 0 = user |
| busy | output | 1 | Instruction in progress |
| xfer_valid | output | 1 | A transfer is presented this cycle |
| xfer_idx | output | 4 | Register index of the transfer |
| xfer_user_bank | output | 1 | 1 = user bank, 0 = current mode bank |
| xfer_addr | output | 32 | Word address of the transfer |
| xfer_write | output | 1 | 1 = memory write (store) |
| psr_restore | output | 1 | Copy saved status to current status |
| illegal | output | 1 | Illegal S combination seen |
| done | output | 1 | Instruction complete |
| wb_valid | output | 1 | Base writeback to apply |
| wb_value | output | 32 | New base value |
| hazard | output | 1 | Block banked reads this cycle |

## Verification
Each addressing mode is run with a different list shape, so that a wrong start offset or a wrong writeback sign shows up as a distinct address. The shapes are sparse lists with register 15, low contiguous lists, and the three-register decrement-before example from base 0x100C. The four S cases are tried separately: load or store, each with and without register 15. This separates status copy from user-bank redirection, and shows that the hazard follows only loads. The S flag combined with writeback, S in user mode, an empty list with and without S, and a start pulse during a running transfer cover the flagged and ignored paths.

// File: rtl/bts_pkg.sv
package bts_pkg;

  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'd0,
    AM_INC_BEFORE = 2'd1,
    AM_DEC_AFTER  = 2'd2,
    AM_DEC_BEFORE = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic load;
    logic user_bank;
    logic restore;
    logic illegal;
    logic wb_ok;
  } xfer_ctl_t;

endpackage

// File: rtl/bts_decode.sv
module bts_decode
  import bts_pkg::*;
#(
  parameter int NREG      = 16,
  parameter int AW        = 32,
  parameter int MODE_W    = 3,
  parameter int USER_MODE = 0,
  parameter int WORD_B    = 4
) (
  input  logic              is_load,
  input  logic              s_flag,
  input  logic              wb_flag,
  input  logic [1:0]        amode,
  input  logic [AW-1:0]     base,
  input  logic [NREG-1:0]   reg_list,
  input  logic [MODE_W-1:0] cur_mode,
  output xfer_ctl_t         ctl,
  output logic [AW-1:0]     first_addr,
  output logic [AW-1:0]     wb_addr,
  output logic              empty
);
  localparam int CNT_W  = $clog2(NREG + 1);
  localparam int PC_IDX = NREG - 1;

  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    span;
  logic             priv;
  logic             s_eff;
  logic             pc_in;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CNT_W'(reg_list[i]);
  end

  assign span  = AW'(cnt) * AW'(WORD_B);
  assign empty = (cnt == '0);
  assign priv  = (cur_mode != MODE_W'(USER_MODE));
  assign s_eff = s_flag && priv;
  assign pc_in = reg_list[PC_IDX];

  always_comb begin
    ctl.load      = is_load;
    ctl.restore   = s_eff && is_load && pc_in;
    ctl.user_bank = s_eff && !(is_load && pc_in);
    ctl.illegal   = s_flag && (!priv || wb_flag);
    ctl.wb_ok     = wb_flag && !s_flag;
  end

  always_comb begin
    unique case (addr_mode_e'(amode))
      AM_INC_AFTER: begin
        first_addr = base;
        wb_addr    = base + span;
      end
      AM_INC_BEFORE: begin
        first_addr = base + AW'(WORD_B);
        wb_addr    = base + span;
      end
      AM_DEC_AFTER: begin
        first_addr = base - span + AW'(WORD_B);
        wb_addr    = base - span;
      end
      default: begin
        first_addr = base - span;
        wb_addr    = base - span;
      end
    endcase
  end

  always_comb begin
    if (ctl.user_bank) AST_BANK_XOR_RESTORE: assert (!ctl.restore); // R3
  end

endmodule

// File: rtl/bts_pick.sv
module bts_pick #(
  parameter int NREG = 16
) (
  input  logic [NREG-1:0]         list,
  output logic [$clog2(NREG)-1:0] idx,
  output logic [NREG-1:0]         rest,
  output logic                    last
);
  localparam int IDX_W = $clog2(NREG);

  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (list[i]) idx = IDX_W'(i);
    end
  end

  assign rest = list & (list - NREG'(1));
  assign last = (rest == '0);

  always_comb begin
    if (list != '0) AST_PICK_LOWEST: assert (list[idx] && ((list ^ rest) == (NREG'(1) << idx))); // R8
  end

endmodule

// File: rtl/bts_seq.sv
module bts_seq
  import bts_pkg::*;
#(
  parameter int NREG      = 16,
  parameter int AW        = 32,
  parameter int MODE_W    = 3,
  parameter int USER_MODE = 0,
  parameter int WORD_B    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    is_load,
  input  logic                    s_flag,
  input  logic                    wb_flag,
  input  logic [1:0]              amode,
  input  logic [AW-1:0]           base,
  input  logic [NREG-1:0]         reg_list,
  input  logic [MODE_W-1:0]       cur_mode,
  output logic                    busy,
  output logic                    xfer_valid,
  output logic [$clog2(NREG)-1:0] xfer_idx,
  output logic                    xfer_user_bank,
  output logic [AW-1:0]           xfer_addr,
  output logic                    xfer_write,
  output logic                    psr_restore,
  output logic                    illegal,
  output logic                    done,
  output logic                    wb_valid,
  output logic [AW-1:0]           wb_value,
  output logic                    hazard
);
  localparam int IDX_W  = $clog2(NREG);
  localparam int PC_IDX = NREG - 1;

  seq_state_e      state;
  xfer_ctl_t       dec_ctl, ctl_q;
  logic [AW-1:0]   dec_first, dec_wb;
  logic            dec_empty;
  logic [NREG-1:0] rem_q, pick_rest;
  logic [IDX_W-1:0] pick_idx;
  logic            pick_last;
  logic [AW-1:0]   addr_q, wbv_q;
  logic            empty_q;

  bts_decode #(
    .NREG(NREG), .AW(AW), .MODE_W(MODE_W), .USER_MODE(USER_MODE), .WORD_B(WORD_B)
  ) u_decode (
    .is_load   (is_load),
    .s_flag    (s_flag),
    .wb_flag   (wb_flag),
    .amode     (amode),
    .base      (base),
    .reg_list  (reg_list),
    .cur_mode  (cur_mode),
    .ctl       (dec_ctl),
    .first_addr(dec_first),
    .wb_addr   (dec_wb),
    .empty     (dec_empty)
  );

  bts_pick #(.NREG(NREG)) u_pick (
    .list(rem_q),
    .idx (pick_idx),
    .rest(pick_rest),
    .last(pick_last)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      ctl_q          <= '0;
      rem_q          <= '0;
      addr_q         <= '0;
      wbv_q          <= '0;
      empty_q        <= 1'b0;
      xfer_valid     <= 1'b0;
      xfer_idx       <= '0;
      xfer_user_bank <= 1'b0;
      xfer_addr      <= '0;
      xfer_write     <= 1'b0;
      psr_restore    <= 1'b0;
      illegal        <= 1'b0;
      done           <= 1'b0;
      wb_valid       <= 1'b0;
      wb_value       <= '0;
      hazard         <= 1'b0;
    end else begin
      xfer_valid     <= 1'b0;
      xfer_idx       <= '0;
      xfer_user_bank <= 1'b0;
      xfer_addr      <= '0;
      xfer_write     <= 1'b0;
      psr_restore    <= 1'b0;
      illegal        <= 1'b0;
      done           <= 1'b0;
      wb_valid       <= 1'b0;
      wb_value       <= '0;
      hazard         <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            ctl_q   <= dec_ctl;
            rem_q   <= reg_list;
            addr_q  <= dec_first;
            wbv_q   <= dec_wb;
            empty_q <= dec_empty;
            illegal <= dec_ctl.illegal;
            state   <= dec_empty ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          xfer_valid     <= 1'b1;
          xfer_idx       <= pick_idx;
          xfer_addr      <= addr_q;
          xfer_user_bank <= ctl_q.user_bank;
          xfer_write     <= !ctl_q.load;
          psr_restore    <= ctl_q.restore && (pick_idx == IDX_W'(PC_IDX));
          rem_q          <= pick_rest;
          addr_q         <= addr_q + AW'(WORD_B);
          if (pick_last) state <= ST_FIN;
        end
        default: begin
          done     <= 1'b1;
          wb_valid <= ctl_q.wb_ok;
          wb_value <= ctl_q.wb_ok ? wbv_q : '0;
          hazard   <= ctl_q.user_bank && ctl_q.load && !empty_q;
          state    <= ST_IDLE;
        end
      endcase
    end
  end

  AST_RESTORE_ON_PC: assert property (@(posedge clk) disable iff (rst)
    psr_restore |-> (xfer_valid && (xfer_idx == IDX_W'(PC_IDX)) && !xfer_write && !xfer_user_bank)); // R1

  AST_WB_BANNED: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (done && !ctl_q.user_bank)); // R4

  AST_ILLEGAL_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($past(start) && !$past(busy))); // R5

  AST_HAZARD_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    hazard |-> (done && !xfer_write)); // R6

  AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && $past(xfer_valid)) |->
      ((xfer_idx > $past(xfer_idx)) && (xfer_addr == $past(xfer_addr) + AW'(WORD_B)))); // R8

  AST_DONE_APART: assert property (@(posedge clk) disable iff (rst)
    !(done && xfer_valid)); // R10

endmodule

// File: tb/bts_seq_test.sv
module bts_seq_test;

  typedef struct packed {
    logic        is_done;
    logic [3:0]  idx;
    logic        ub;
    logic [31:0] addr;
    logic        wr;
    logic        rs;
    logic        wbv;
    logic [31:0] wbval;
    logic        hz;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        is_load = 1'b0;
  logic        s_flag = 1'b0;
  logic        wb_flag = 1'b0;
  logic [1:0]  amode = 2'd0;
  logic [31:0] base = '0;
  logic [15:0] reg_list = '0;
  logic [2:0]  cur_mode = 3'd3;
  logic        busy, xfer_valid, xfer_user_bank, xfer_write, psr_restore;
  logic        illegal, done, wb_valid, hazard;
  logic [3:0]  xfer_idx;
  logic [31:0] xfer_addr, wb_value;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  item_t exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  bts_seq uut (
    .clk(clk), .rst(rst), .start(start), .is_load(is_load), .s_flag(s_flag),
    .wb_flag(wb_flag), .amode(amode), .base(base), .reg_list(reg_list),
    .cur_mode(cur_mode), .busy(busy), .xfer_valid(xfer_valid), .xfer_idx(xfer_idx),
    .xfer_user_bank(xfer_user_bank), .xfer_addr(xfer_addr), .xfer_write(xfer_write),
    .psr_restore(psr_restore), .illegal(illegal), .done(done), .wb_valid(wb_valid),
    .wb_value(wb_value), .hazard(hazard)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && (xfer_valid || done)) begin
      item_t act;
      act.is_done = done;
      act.idx     = xfer_idx;
      act.ub      = xfer_user_bank;
      act.addr    = xfer_addr;
      act.wr      = xfer_write;
      act.rs      = psr_restore;
      act.wbv     = wb_valid;
      act.wbval   = wb_value;
      act.hz      = hazard;
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected output", 128'(act), 128'(0));
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(act == e, t, 128'(act), 128'(e));
      end
    end
  end

  task automatic run_instr(input bit ld, input bit s, input bit wb, input logic [1:0] am,
                           input logic [31:0] b, input logic [15:0] lst,
                           input logic [2:0] md, input string tag);
    int n = 0;
    logic [31:0] a, wv;
    bit priv, ub, rs, ill, wbok, hz;
    for (int i = 0; i < 16; i++) n += int'(lst[i]);
    priv = (md != 3'd0);
    ub   = s && priv && !(ld && lst[15]);
    rs   = s && priv && ld && lst[15];
    ill  = s && (!priv || wb);
    wbok = wb && !s;
    hz   = ub && ld && (n != 0);
    case (am)
      2'd0: begin a = b;                  wv = b + 32'(4 * n); end
      2'd1: begin a = b + 4;              wv = b + 32'(4 * n); end
      2'd2: begin a = b - 32'(4 * n) + 4; wv = b - 32'(4 * n); end
      default: begin a = b - 32'(4 * n); wv = b - 32'(4 * n); end
    endcase
    for (int i = 0; i < 16; i++) begin
      if (lst[i]) begin
        item_t it;
        it = '0;
        it.idx  = 4'(i);
        it.ub   = ub;
        it.addr = a;
        it.wr   = !ld;
        it.rs   = rs && (i == 15);
        exp_q.push_back(it);
        tag_q.push_back({tag, " transfer"});
        a = a + 4;
      end
    end
    begin
      item_t d;
      d = '0;
      d.is_done = 1'b1;
      d.wbv     = wbok;
      d.wbval   = wbok ? wv : 32'h0;
      d.hz      = hz;
      exp_q.push_back(d);
      tag_q.push_back({tag, " done"});
    end
    @(negedge clk);
    is_load = ld; s_flag = s; wb_flag = wb; amode = am; base = b;
    reg_list = lst; cur_mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(illegal == ill, {tag, " illegal"}, 128'(illegal), 128'(ill));
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check({busy, xfer_valid, xfer_idx, xfer_user_bank, xfer_addr, xfer_write, psr_restore,
           illegal, done, wb_valid, wb_value, hazard} == '0, "R11 reset outputs",
          128'({busy, xfer_valid, done, wb_valid, hazard}), 128'(0));

    run_instr(1, 0, 1, 2'd0, 32'h0000_4000, 16'h80F1, 3'd3, "R7 R8 inc-after load");
    run_instr(0, 0, 1, 2'd1, 32'h0000_2000, 16'h8421, 3'd3, "R7 inc-before store");
    run_instr(1, 0, 1, 2'd2, 32'h0000_3000, 16'h0007, 3'd3, "R7 dec-after load");
    run_instr(0, 0, 1, 2'd3, 32'h0000_100C, 16'h00A2, 3'd3, "R7 dec-before 0x100C");
    run_instr(1, 1, 0, 2'd0, 32'h0000_5000, 16'h8003, 3'd3, "R1 load S with pc");
    run_instr(0, 1, 0, 2'd1, 32'h0000_6000, 16'h8010, 3'd3, "R2 store S with pc");
    run_instr(1, 1, 0, 2'd2, 32'h0000_7000, 16'h0030, 3'd3, "R3 R6 load S user bank");
    run_instr(0, 1, 0, 2'd3, 32'h0000_8000, 16'h0C00, 3'd3, "R3 R6 store S user bank");
    run_instr(1, 1, 1, 2'd0, 32'h0000_9000, 16'h0101, 3'd3, "R4 S with writeback");
    run_instr(0, 0, 1, 2'd0, 32'h0000_9100, 16'h0002, 3'd3, "R4 writeback without S");
    run_instr(1, 1, 0, 2'd0, 32'h0000_A000, 16'h8001, 3'd0, "R5 user mode S");
    run_instr(1, 0, 1, 2'd3, 32'h0000_B000, 16'h0000, 3'd3, "R9 empty list");
    run_instr(1, 1, 0, 2'd0, 32'h0000_B100, 16'h0000, 3'd3, "R9 R6 empty S load");

    // R10 start while busy is ignored
    run_instr_busy();

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 scoreboard drained", 128'(exp_q.size()), 128'(0));
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic run_instr_busy();
    fork
      run_instr(1, 0, 0, 2'd1, 32'h0000_C000, 16'h001E, 3'd3, "R10 busy ignore");
      begin
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R10 busy while running", 128'(busy), 128'(1));
        start = 1'b1; is_load = 1'b0; reg_list = 16'hFFFF; base = 32'h0000_F000;
        @(negedge clk);
        start = 1'b0;
      end
    join
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule